// File: doc/BRIEF.md
# Two-Address Operand Specifier Decoder

This block turns the operand-specifier fields of a 16-bit two-address instruction into a resolved description of both operands. Its inputs are the 2-bit source mode field, the source register number, the single destination mode bit, the destination register number and the byte/word select. From these it produces a named source mode, a named destination mode, a hard-wired constant when the source fields select one, a flag for each operand that says whether an extension word follows, and the step by which the source register is incremented after use.

Two registers have special roles. The program counter (register 0) and the status register (register 2) change the meaning of the indexed and auto-increment modes. Register 3, and register 2 in its two indirect modes, address nothing at all and instead supply a small constant. The block is purely combinational, with no clock and no state. An instruction-length counter and an operand fetch stage sit downstream and use its outputs directly.

Top module: `opspec_decoder`

## Requirements
- R1: For source registers 1 and 4 to 15, src_as 00/01/10/11 gives src_mode 0 (register), 1 (indexed), 4 (indirect) and 5 (indirect auto-increment).
- R2: With source register 3, src_mode is 7 (constant), const_valid is 1, and src_as 00/01/10/11 gives const_val 0x0000, 0x0001, 0x0002 and 0xFFFF for word operations.
- R3: With source register 2, src_as 00 gives src_mode 0 and src_as 01 gives src_mode 3 (absolute). src_as 10 and 11 give src_mode 7 with const_val 0x0004 and 0x0008.
- R4: With source register 0, src_as 01 gives src_mode 2 (symbolic) and src_as 11 gives src_mode 6 (immediate). src_as 00 and 10 give modes 0 and 4.
- R5: When byte_op is 1, the all-ones constant (register 3, src_as 11) is presented as 0x00FF.
- R6: dst_ad 0 gives dst_mode 0. dst_ad 1 gives dst_mode 2 for register 0, dst_mode 3 for register 2 and dst_mode 1 for any other register.
- R7: src_ext is 1 exactly when src_mode is 1, 2, 3 or 6, so a constant never requests an extension word.
- R8: dst_ext equals dst_ad for every destination register.
- R9: post_inc is 1 for byte and 2 for word when src_mode is 5, and 0 in every other mode.
- R10: When no constant is selected, const_valid is 0 and const_val is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_as | input | 2 | Source addressing mode field |
| src_reg | input | 4 | Source register number |
| dst_ad | input | 1 | Destination addressing mode bit |
| dst_reg | input | 4 | Destination register number |
| byte_op | input | 1 | 1 = byte operation, 0 = word operation |
| src_mode | output | 3 | Resolved source mode code |
| dst_mode | output | 3 | Resolved destination mode code |
| const_val | output | 16 | Generated constant, zero when none |
| const_valid | output | 1 | A constant is generated |
| src_ext | output | 1 | Source needs an extension word |
| dst_ext | output | 1 | Destination needs an extension word |
| post_inc | output | 2 | Source register post-increment amount |

## Verification
Every output is a function of the inputs that are present in the same cycle, so each result is due zero clock edges after its stimulus. The bench applies one input vector shortly after a rising edge and compares all seven outputs against its behavioural model at the following falling edge. It walks all 4096 combinations of the inputs, so every register special case is met in both byte and word form and no result is read while the inputs are still changing.

// File: rtl/opspec_pkg.sv
package opspec_pkg;

    localparam int REG_W  = 4;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int INC_W  = 2;

    localparam logic [REG_W-1:0] IDX_PC = REG_W'(0);
    localparam logic [REG_W-1:0] IDX_SR = REG_W'(2);
    localparam logic [REG_W-1:0] IDX_CG = REG_W'(3);

    typedef enum logic [2:0] {
        AM_REG       = 3'd0,
        AM_INDEXED   = 3'd1,
        AM_SYMBOLIC  = 3'd2,
        AM_ABSOLUTE  = 3'd3,
        AM_INDIRECT  = 3'd4,
        AM_AUTOINC   = 3'd5,
        AM_IMMEDIATE = 3'd6,
        AM_CONST     = 3'd7
    } addr_mode_e;

    typedef enum logic [2:0] {
        CG_ZERO  = 3'd0,
        CG_ONE   = 3'd1,
        CG_TWO   = 3'd2,
        CG_FOUR  = 3'd3,
        CG_EIGHT = 3'd4,
        CG_ONES  = 3'd5
    } cg_sel_e;

    typedef struct packed {
        addr_mode_e       mode;
        logic             ext;
        logic             cg_hit;
        cg_sel_e          cg_sel;
        logic [INC_W-1:0] inc;
    } src_info_t;

    function automatic logic mode_needs_ext(addr_mode_e m);
        return (m == AM_INDEXED) || (m == AM_SYMBOLIC) ||
               (m == AM_ABSOLUTE) || (m == AM_IMMEDIATE);
    endfunction

endpackage

// File: rtl/opspec_src_dec.sv
module opspec_src_dec
    import opspec_pkg::*;
(
    input  logic [1:0]       as_i,
    input  logic [REG_W-1:0] reg_i,
    input  logic             byte_i,
    output src_info_t        info_o
);
    src_info_t info;

    always_comb begin
        info        = '0;
        info.mode   = AM_REG;
        info.cg_sel = CG_ZERO;
        if (reg_i == IDX_CG) begin
            info.mode   = AM_CONST;
            info.cg_hit = 1'b1;
            unique case (as_i)
                2'b00:   info.cg_sel = CG_ZERO;
                2'b01:   info.cg_sel = CG_ONE;
                2'b10:   info.cg_sel = CG_TWO;
                default: info.cg_sel = CG_ONES;
            endcase
        end else if (reg_i == IDX_SR && as_i[1]) begin
            info.mode   = AM_CONST;
            info.cg_hit = 1'b1;
            info.cg_sel = as_i[0] ? CG_EIGHT : CG_FOUR;
        end else begin
            unique case (as_i)
                2'b00:   info.mode = AM_REG;
                2'b01:   info.mode = (reg_i == IDX_PC) ? AM_SYMBOLIC :
                                     (reg_i == IDX_SR) ? AM_ABSOLUTE : AM_INDEXED;
                2'b10:   info.mode = AM_INDIRECT;
                default: info.mode = (reg_i == IDX_PC) ? AM_IMMEDIATE : AM_AUTOINC;
            endcase
        end
        info.ext = mode_needs_ext(info.mode);
        if (info.mode == AM_AUTOINC)
            info.inc = byte_i ? INC_W'(1) : INC_W'(2);
    end

    assign info_o = info;
endmodule

// File: rtl/opspec_dst_dec.sv
module opspec_dst_dec
    import opspec_pkg::*;
(
    input  logic             ad_i,
    input  logic [REG_W-1:0] reg_i,
    output addr_mode_e       mode_o,
    output logic             ext_o
);
    always_comb begin
        if (!ad_i)
            mode_o = AM_REG;
        else if (reg_i == IDX_PC)
            mode_o = AM_SYMBOLIC;
        else if (reg_i == IDX_SR)
            mode_o = AM_ABSOLUTE;
        else
            mode_o = AM_INDEXED;
    end

    assign ext_o = ad_i;
endmodule

// File: rtl/opspec_const_gen.sv
module opspec_const_gen
    import opspec_pkg::*;
(
    input  logic              hit_i,
    input  cg_sel_e           sel_i,
    input  logic              byte_i,
    output logic [DATA_W-1:0] val_o
);
    localparam logic [DATA_W-1:0] BYTE_ONES = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

    always_comb begin
        val_o = '0;
        if (hit_i) begin
            unique case (sel_i)
                CG_ONE:   val_o = DATA_W'(1);
                CG_TWO:   val_o = DATA_W'(2);
                CG_FOUR:  val_o = DATA_W'(4);
                CG_EIGHT: val_o = DATA_W'(8);
                CG_ONES:  val_o = byte_i ? BYTE_ONES : '1;
                default:  val_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/opspec_decoder.sv
module opspec_decoder
    import opspec_pkg::*;
(
    input  logic [1:0]        src_as,
    input  logic [REG_W-1:0]  src_reg,
    input  logic              dst_ad,
    input  logic [REG_W-1:0]  dst_reg,
    input  logic              byte_op,
    output logic [2:0]        src_mode,
    output logic [2:0]        dst_mode,
    output logic [DATA_W-1:0] const_val,
    output logic              const_valid,
    output logic              src_ext,
    output logic              dst_ext,
    output logic [INC_W-1:0]  post_inc
);
    src_info_t  s_info;
    addr_mode_e d_mode;

    opspec_src_dec u_src (
        .as_i   (src_as),
        .reg_i  (src_reg),
        .byte_i (byte_op),
        .info_o (s_info)
    );

    opspec_dst_dec u_dst (
        .ad_i   (dst_ad),
        .reg_i  (dst_reg),
        .mode_o (d_mode),
        .ext_o  (dst_ext)
    );

    opspec_const_gen u_cg (
        .hit_i  (s_info.cg_hit),
        .sel_i  (s_info.cg_sel),
        .byte_i (byte_op),
        .val_o  (const_val)
    );

    assign src_mode    = s_info.mode;
    assign dst_mode    = d_mode;
    assign const_valid = s_info.cg_hit;
    assign src_ext     = s_info.ext;
    assign post_inc    = s_info.inc;

    // Cross-module consistency checks on the combined outputs
    always_comb begin
        p_const_no_ext_r7: assert (!(const_valid && src_ext));
        p_inc_only_autoinc_r9: assert ((post_inc == '0) || (src_mode == AM_AUTOINC));
        p_idle_const_zero_r10: assert (const_valid || (const_val == '0));
        p_byte_const_narrow_r5: assert (!(const_valid && byte_op) ||
                                        (const_val[DATA_W-1:BYTE_W] == '0));
        p_dst_mode_range_r6: assert (dst_mode[2] == 1'b0);
        p_dst_ext_follows_ad_r8: assert (dst_ext == (dst_mode != AM_REG));
    end
endmodule

// File: tb/tb_opspec_decoder.sv
module tb_opspec_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  src_as = '0;
    logic [3:0]  src_reg = '0;
    logic        dst_ad = 1'b0;
    logic [3:0]  dst_reg = '0;
    logic        byte_op = 1'b0;
    logic [2:0]  src_mode, dst_mode;
    logic [15:0] const_val;
    logic        const_valid, src_ext, dst_ext;
    logic [1:0]  post_inc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    opspec_decoder dut (
        .src_as(src_as), .src_reg(src_reg), .dst_ad(dst_ad), .dst_reg(dst_reg),
        .byte_op(byte_op), .src_mode(src_mode), .dst_mode(dst_mode),
        .const_val(const_val), .const_valid(const_valid), .src_ext(src_ext),
        .dst_ext(dst_ext), .post_inc(post_inc)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s as=%0d sreg=%0d ad=%0d dreg=%0d bw=%0d actual=0x%0h expected=0x%0h",
                     req, src_as, src_reg, dst_ad, dst_reg, byte_op, act, exp);
        end
    endtask

    // Behavioural reference model built from the requirements
    task automatic compare_all();
        int a = int'(src_as);
        int r = int'(src_reg);
        int bw = int'(byte_op);
        int m_src, m_dst, c_val, c_vld, e_src, e_dst, inc;
        string tag_src, tag_cv;
        int general_modes[4] = '{0, 1, 4, 5};

        c_vld = 0; c_val = 0;
        if (r == 3) begin
            c_vld = 1; m_src = 7;
            c_val = (a == 0) ? 0 : (a == 1) ? 1 : (a == 2) ? 2 : (bw ? 255 : 65535);
        end else if (r == 2 && a >= 2) begin
            c_vld = 1; m_src = 7;
            c_val = (a == 2) ? 4 : 8;
        end else if (r == 2 && a == 1) m_src = 3;
        else if (r == 0 && a == 1)     m_src = 2;
        else if (r == 0 && a == 3)     m_src = 6;
        else                           m_src = general_modes[a];

        e_src = (m_src == 1 || m_src == 2 || m_src == 3 || m_src == 6) ? 1 : 0;
        inc   = (m_src == 5) ? (bw ? 1 : 2) : 0;
        m_dst = !dst_ad ? 0 : (dst_reg == 0) ? 2 : (dst_reg == 2) ? 3 : 1;
        e_dst = int'(dst_ad);

        tag_src = (r == 3) ? "R2" : (r == 2) ? "R3" : (r == 0) ? "R4" : "R1";
        if (c_vld == 0)               tag_cv = "R10";
        else if (r == 3 && a == 3 && bw == 1) tag_cv = "R5";
        else if (r == 3)              tag_cv = "R2";
        else                          tag_cv = "R3";

        check(tag_src, int'(src_mode), m_src);
        check(tag_cv, int'(const_val), c_val);
        check(tag_cv, int'(const_valid), c_vld);
        check("R6", int'(dst_mode), m_dst);
        check("R7", int'(src_ext), e_src);
        check("R8", int'(dst_ext), e_dst);
        check("R9", int'(post_inc), inc);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state: all-zero fields decode to register mode, no constant (R1, R10)
        @(negedge clk);
        check("R1", int'(src_mode), 0);
        check("R10", int'(const_valid), 0);
        // Exhaustive sweep: one vector per cycle, compared at the falling edge
        for (int v = 0; v < 4096; v++) begin
            @(posedge clk);
            #1;
            {byte_op, dst_ad, dst_reg, src_as, src_reg} = 12'(v);
            @(negedge clk);
            compare_all();
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule